// File: doc/BRIEF.md
# Microcoded Datapath Sequencer

This block runs horizontal microcode over a 16-bit internal bus. Every microword drives the whole datapath directly in a single clock: it picks a bus source, an ALU function, an optional shift on the write-back path, loads of the two scratch registers and the memory address register, writes to a 32-entry register bank or to a small data memory, and it names the address of the word that follows. No microprogram counter increments. The successor always comes from the word itself.

The 1024-word control store is a writable RAM. It is filled through a valid/ready write stream while the block is held (`run` low). Raising `run` starts execution at the current microaddress, which reset sets to zero. Lowering `run` freezes all state and reopens the write stream. The data memory is a simple synchronous model. Its read data is registered, so a word that loads the address register must be followed by one word that does not use the memory-data source.

Top module: `useq_core`

## Requirements
- R1: After reset the microaddress, T, L and the address register read zero, all 32 general registers hold zero, and `cs_wr_ready` is high while `run` is low.
- R2: A microword packs, from bit 31 down, register select [31:27], ALU function [26:23], bus source [22:20], special function one [19:16], special function two [15:12], T load [11], L load [10] and successor address [9:0]. In each clock with `run` high, the microaddress becomes the successor field of the word executed, with no incrementing.
- R3: `cs_wr_ready` equals the inverse of `run`. A control-store word is written only in a clock where valid and ready are both high. A write offered while running is dropped and leaves the stored word unchanged.
- R4: Bus source codes: 0 is the general register named by register select, 1 is L, 2 is memory data, 3 is register select zero-extended as a constant, 4 is all ones, and 5 to 7 drive zero.
- R5: ALU input A is the bus and input B is T. Function codes: 0 A, 1 B, 2 A+B, 3 A−B, 4 A&B, 5 A|B, 6 A^B, 7 A+1, 8 A−1, 9 ~A, 10 A+B+1, 11 A&~B, 12 to 15 A. All results are taken modulo 2^16.
- R6: The T load bit and the L load bit each capture the unshifted ALU result, independently of each other. A register whose bit is clear keeps its value.
- R7: Special function one selects the shift applied to the ALU result on the register write-back path: 2 shifts left by one, 3 shifts right by one (logical), 4 rotates left by one, 5 rotates right by one, and any other code passes the result unchanged.
- R8: Special function two code 2 writes the shifter output into the general register named by register select. The other registers are unaffected.
- R9: Special function one code 1 loads the full 16-bit ALU result into the address register, which is visible on `mar_o`.
- R10: Special function two code 1 writes the ALU result to data memory at the low address-register bits. Memory-data source reads give the word at the address-register value once one microword has run since that register was loaded.
- R11: While `run` is low, the microaddress, T, L, the address register, the general registers and the data memory do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: execute one microword per clock; low: hold |
| cs_wr_valid | input | 1 | Control-store write offered |
| cs_wr_ready | output | 1 | Control-store write accepted (only while held) |
| cs_wr_addr | input | 10 | Control-store write address |
| cs_wr_data | input | 32 | Microword to store |
| upc_o | output | 10 | Current microaddress |
| t_o | output | 16 | T register |
| l_o | output | 16 | L register |
| mar_o | output | 16 | Memory address register |

## Verification
The assertions take two things for granted about the microcode. No word that directly follows an address-register load selects the memory-data source. Every word is stored before it is executed. Held clocks do not count as the idle word, because the memory read register is also frozen while `run` is low. Every program in the stimulus puts a constant-source or idle word after each address load, and each program is written completely while `run` is low before it is started from a reset.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int DW     = 16;
  localparam int UW     = 32;
  localparam int RSEL_W = 5;
  localparam int ALUF_W = 4;
  localparam int BS_W   = 3;
  localparam int FN_W   = 4;
  localparam int NEXT_W = 10;
  localparam int NREG   = 1 << RSEL_W;

  typedef struct packed {
    logic [RSEL_W-1:0] rsel;
    logic [ALUF_W-1:0] aluf;
    logic [BS_W-1:0]   bs;
    logic [FN_W-1:0]   f1;
    logic [FN_W-1:0]   f2;
    logic              lt;
    logic              ll;
    logic [NEXT_W-1:0] nxt;
  } uword_t;

  typedef enum logic [BS_W-1:0] {
    BS_REG   = 3'd0,
    BS_L     = 3'd1,
    BS_MD    = 3'd2,
    BS_CONST = 3'd3,
    BS_ONES  = 3'd4
  } bus_src_e;

  typedef enum logic [ALUF_W-1:0] {
    ALU_A     = 4'd0,
    ALU_B     = 4'd1,
    ALU_ADD   = 4'd2,
    ALU_SUB   = 4'd3,
    ALU_AND   = 4'd4,
    ALU_OR    = 4'd5,
    ALU_XOR   = 4'd6,
    ALU_INC   = 4'd7,
    ALU_DEC   = 4'd8,
    ALU_NOT   = 4'd9,
    ALU_ADDC  = 4'd10,
    ALU_ANDN  = 4'd11
  } alu_fn_e;

  typedef enum logic [FN_W-1:0] {
    F1_NONE = 4'd0,
    F1_MAR  = 4'd1,
    F1_SHL  = 4'd2,
    F1_SHR  = 4'd3,
    F1_ROL  = 4'd4,
    F1_ROR  = 4'd5
  } f1_e;

  typedef enum logic [FN_W-1:0] {
    F2_NONE = 4'd0,
    F2_MEMW = 4'd1,
    F2_REGW = 4'd2
  } f2_e;
endpackage

// File: rtl/useq_cstore.sv
module useq_cstore #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  // combinational fetch: one microword per clock, no fetch stage
  assign rdata = words[raddr];
endmodule

// File: rtl/useq_regbank.sv
module useq_regbank #(
  parameter int N  = 32,
  parameter int AW = 5,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= '0;
      else if (we && (waddr == AW'(i)))    regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/useq_alu.sv
module useq_alu
  import useq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [ALUF_W-1:0] fn,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      y
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (fn)
      ALU_A:    y = a;
      ALU_B:    y = b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_INC:  y = a + ONE;
      ALU_DEC:  y = a - ONE;
      ALU_NOT:  y = ~a;
      ALU_ADDC: y = a + b + ONE;
      ALU_ANDN: y = a & ~b;
      default:  y = a;
    endcase
  end
endmodule

// File: rtl/useq_shift.sv
module useq_shift
  import useq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [FN_W-1:0] mode,
  input  logic [W-1:0]    d,
  output logic [W-1:0]    y
);
  always_comb begin
    case (mode)
      F1_SHL:  y = {d[W-2:0], 1'b0};
      F1_SHR:  y = {1'b0, d[W-1:1]};
      F1_ROL:  y = {d[W-2:0], d[W-1]};
      F1_ROR:  y = {d[0], d[W-1:1]};
      default: y = d;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cs_wr_valid,
  output logic              cs_wr_ready,
  input  logic [NEXT_W-1:0] cs_wr_addr,
  input  logic [UW-1:0]     cs_wr_data,
  output logic [NEXT_W-1:0] upc_o,
  output logic [DW-1:0]     t_o,
  output logic [DW-1:0]     l_o,
  output logic [DW-1:0]     mar_o
);
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [UW-1:0]     cs_rdata;
  uword_t            uw;
  logic [NEXT_W-1:0] upc_q;
  logic [DW-1:0]     t_q, l_q, mar_q, md_q;
  logic [DW-1:0]     rf_rdata, bus, alu_res, shf_res;
  logic              cs_we, rf_we, mem_we;
  logic [DW-1:0]     dmem [MEM_DEPTH];

  assign cs_wr_ready = ~run;
  assign cs_we       = cs_wr_valid & cs_wr_ready;
  assign uw          = cs_rdata;
  assign rf_we       = run && (uw.f2 == F2_REGW);
  assign mem_we      = run && (uw.f2 == F2_MEMW);

  useq_cstore #(.AW(NEXT_W), .W(UW)) u_cstore (
    .clk   (clk),
    .we    (cs_we),
    .waddr (cs_wr_addr),
    .wdata (cs_wr_data),
    .raddr (upc_q),
    .rdata (cs_rdata)
  );

  useq_regbank #(.N(NREG), .AW(RSEL_W), .W(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (uw.rsel),
    .wdata (shf_res),
    .raddr (uw.rsel),
    .rdata (rf_rdata)
  );

  // processor bus source select
  always_comb begin
    case (uw.bs)
      BS_REG:   bus = rf_rdata;
      BS_L:     bus = l_q;
      BS_MD:    bus = md_q;
      BS_CONST: bus = {{(DW-RSEL_W){1'b0}}, uw.rsel};
      BS_ONES:  bus = '1;
      default:  bus = '0;
    endcase
  end

  useq_alu #(.W(DW)) u_alu (
    .fn (uw.aluf),
    .a  (bus),
    .b  (t_q),
    .y  (alu_res)
  );

  useq_shift #(.W(DW)) u_shift (
    .mode (uw.f1),
    .d    (alu_res),
    .y    (shf_res)
  );

  // sequencer and scratch registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q <= '0;
      t_q   <= '0;
      l_q   <= '0;
      mar_q <= '0;
      md_q  <= '0;
    end else if (run) begin
      upc_q <= uw.nxt;
      if (uw.lt)            t_q   <= alu_res;
      if (uw.ll)            l_q   <= alu_res;
      if (uw.f1 == F1_MAR)  mar_q <= alu_res;
      md_q <= dmem[mar_q[MEM_AW-1:0]];
    end
  end

  // simple data memory model
  always_ff @(posedge clk) begin
    if (mem_we) dmem[mar_q[MEM_AW-1:0]] <= alu_res;
  end

  assign upc_o = upc_q;
  assign t_o   = t_q;
  assign l_o   = l_q;
  assign mar_o = mar_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [NEXT_W-1:0] upc,
  input uword_t            uw,
  input logic [DW-1:0]     alu_res,
  input logic [DW-1:0]     t_q,
  input logic [DW-1:0]     l_q,
  input logic [DW-1:0]     mar_q
);
  logic mar_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mar_prev <= 1'b0;
    else if (run) mar_prev <= (uw.f1 == F1_MAR);
  end

  p_next_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> upc == $past(uw.nxt));

  p_hold_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(upc) && $stable(t_q) && $stable(l_q) && $stable(mar_q));

  p_t_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && uw.lt |=> t_q == $past(alu_res));

  p_l_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && !uw.ll |=> $stable(l_q));

  p_mar_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && (uw.f1 == F1_MAR) |=> mar_q == $past(alu_res));

  p_md_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && mar_prev |-> uw.bs != BS_MD);
endmodule

bind useq_core useq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .upc     (upc_q),
  .uw      (uw),
  .alu_res (alu_res),
  .t_q     (t_q),
  .l_q     (l_q),
  .mar_q   (mar_q)
);

// File: tb/useq_core_tb.sv
module useq_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cs_wr_valid = 1'b0;
  logic        cs_wr_ready;
  logic [9:0]  cs_wr_addr = '0;
  logic [31:0] cs_wr_data = '0;
  logic [9:0]  upc_o;
  logic [15:0] t_o, l_o, mar_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  useq_core u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cs_wr_valid (cs_wr_valid),
    .cs_wr_ready (cs_wr_ready),
    .cs_wr_addr  (cs_wr_addr),
    .cs_wr_data  (cs_wr_data),
    .upc_o       (upc_o),
    .t_o         (t_o),
    .l_o         (l_o),
    .mar_o       (mar_o)
  );

  function automatic logic [31:0] mk(int rs, int af, int bs, int f1, int f2,
                                     int lt, int ll, int nx);
    return {rs[4:0], af[3:0], bs[2:0], f1[3:0], f2[3:0], lt[0], ll[0], nx[9:0]};
  endfunction

  function automatic int alu_ref(int f, int a, int b);
    int r;
    case (f)
      1:  r = b;
      2:  r = a + b;
      3:  r = a - b + 65536;
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  r = a + 1;
      8:  r = a + 65535;
      9:  r = 65535 - a;
      10: r = a + b + 1;
      11: r = a & (65535 - b);
      default: r = a;
    endcase
    return r % 65536;
  endfunction

  function automatic int shf_ref(int m, int v);
    case (m)
      2: return (v * 2) % 65536;
      3: return v / 2;
      4: return ((v * 2) % 65536) + (v / 32768);
      5: return (v / 2) + ((v % 2) * 32768);
      default: return v;
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cs_wr_valid = 1'b1;
    cs_wr_addr  = a[9:0];
    cs_wr_data  = d;
    @(negedge clk);
    cs_wr_valid = 1'b0;
  endtask

  task automatic restart();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go(input int n);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  int chain [5] = '{0, 37, 900, 5, 1023};

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "upc", upc_o, 0);
    chk("R1", "T", t_o, 0);
    chk("R1", "L", l_o, 0);
    chk("R1", "mar", mar_o, 0);
    chk("R1", "ready", cs_wr_ready, 1);
    rst_n = 1'b1;
    // R1: general register cleared by reset
    wr(0, mk(0, 0, 4, 0, 0, 0, 1, 1));
    wr(1, mk(7, 0, 0, 0, 0, 0, 1, 1));
    restart();
    go(1);
    chk("R1", "L all-ones load", l_o, 16'hFFFF);
    go(1);
    chk("R1", "register 7 after reset", l_o, 0);

    // R4: unused bus sources drive zero
    wr(0, mk(0, 0, 4, 0, 0, 0, 1, 1));
    wr(1, mk(0, 0, 6, 0, 0, 0, 1, 2));
    wr(2, mk(0, 7, 7, 0, 0, 0, 1, 2));
    restart();
    go(2);
    chk("R4", "source 6 zero", l_o, 0);
    go(1);
    chk("R4", "source 7 zero plus one", l_o, 1);

    // R5: ALU sweep, A = bus, B = T
    for (int ti = 0; ti < 5; ti++) begin
      for (int bi = 0; bi < 4; bi++) begin
        for (int f = 0; f < 16; f++) begin
          int tv, bv;
          tv = (ti == 4) ? 65535 : ((ti == 0) ? 0 : ((ti == 1) ? 1 : ((ti == 2) ? 5 : 31)));
          bv = (bi == 3) ? 65535 : ((bi == 0) ? 0 : ((bi == 1) ? 3 : 31));
          wr(0, mk((ti == 4) ? 0 : tv, 0, (ti == 4) ? 4 : 3, 0, 0, 1, 0, 1));
          wr(1, mk((bi == 3) ? 0 : bv, f, (bi == 3) ? 4 : 3, 0, 0, 0, 1, 1));
          restart();
          go(2);
          chk("R5", $sformatf("fn %0d bus %h T %h", f, bv, tv), l_o, alu_ref(f, bv, tv));
        end
      end
    end

    // R2: successor chain, not incrementing
    for (int i = 0; i < 5; i++)
      wr(chain[i], mk(10 + i, 0, 3, 0, 0, 0, 1, chain[(i + 1) % 5]));
    restart();
    for (int s = 1; s <= 7; s++) begin
      go(1);
      chk("R2", $sformatf("upc step %0d", s), upc_o, chain[s % 5]);
      chk("R2", $sformatf("L step %0d", s), l_o, 10 + ((s - 1) % 5));
    end

    // R3: write while running is refused
    run = 1'b1;
    cs_wr_valid = 1'b1;
    cs_wr_addr = 10'd900;
    cs_wr_data = mk(30, 0, 3, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R3", "ready while running", cs_wr_ready, 0);
    cs_wr_valid = 1'b0;
    run = 1'b0;
    @(negedge clk);
    chk("R3", "ready while held", cs_wr_ready, 1);
    restart();
    go(3);
    chk("R3", "word at 900 unchanged", l_o, 12);

    // R6: independent T and L loads; R11: hold in the middle
    wr(0, mk(7, 0, 3, 0, 0, 1, 1, 1));
    wr(1, mk(9, 0, 3, 0, 0, 1, 0, 2));
    wr(2, mk(4, 0, 3, 0, 0, 0, 1, 3));
    wr(3, mk(2, 0, 3, 0, 0, 0, 0, 3));
    restart();
    go(1);
    chk("R6", "both T", t_o, 7);
    chk("R6", "both L", l_o, 7);
    repeat (5) @(negedge clk);
    chk("R11", "upc held", upc_o, 1);
    chk("R11", "T held", t_o, 7);
    chk("R11", "L held", l_o, 7);
    go(1);
    chk("R6", "T only: T", t_o, 9);
    chk("R6", "T only: L", l_o, 7);
    go(1);
    chk("R6", "L only: T", t_o, 9);
    chk("R6", "L only: L", l_o, 4);
    go(1);
    chk("R6", "neither: T", t_o, 9);
    chk("R6", "neither: L", l_o, 4);

    // R7 / R8: shifter on write-back, T unshifted
    for (int mi = 0; mi < 6; mi++) begin
      for (int c = 0; c < 32; c++) begin
        for (int inv = 0; inv < 2; inv++) begin
          int m, v;
          m = (mi == 0) ? 0 : ((mi == 5) ? 6 : mi + 1);
          v = (inv == 1) ? 65535 - c : c;
          wr(0, mk(c, (inv == 1) ? 9 : 0, 3, m, 2, 1, 0, 1));
          wr(1, mk(c, 0, 0, 0, 0, 0, 1, 1));
          restart();
          go(2);
          chk("R7", $sformatf("mode %0d v %h", m, v), l_o, shf_ref(m, v));
          chk("R6", $sformatf("T unshifted v %h", v), t_o, v);
        end
      end
    end

    // R8 / R4: separate registers and the L source
    wr(0, mk(5, 0, 3, 0, 0, 1, 0, 1));
    wr(1, mk(3, 2, 3, 0, 2, 0, 0, 2));
    wr(2, mk(4, 2, 3, 0, 2, 0, 0, 3));
    wr(3, mk(3, 0, 0, 0, 0, 0, 1, 4));
    wr(4, mk(0, 7, 1, 0, 0, 1, 0, 4));
    restart();
    go(4);
    chk("R8", "register 3 kept after register 4 write", l_o, 8);
    go(1);
    chk("R4", "L source plus one", t_o, 9);

    // R9 / R10: address register and data memory
    for (int c = 0; c < 32; c++) begin
      wr(0, mk(c, 0, 3, 1, 0, 0, 0, 1));
      wr(1, mk(31 - c, 9, 3, 0, 1, 0, 0, 2));
      wr(2, mk(0, 0, 5, 0, 0, 0, 0, 3));
      wr(3, mk(0, 0, 2, 0, 0, 0, 1, 3));
      restart();
      go(4);
      chk("R9", $sformatf("mar %0d", c), mar_o, c);
      chk("R10", $sformatf("read back %0d", c), l_o, 65535 - (31 - c));
    end
    wr(0, mk(5, 0, 3, 1, 0, 0, 0, 1));
    wr(1, mk(0, 0, 5, 0, 0, 0, 0, 2));
    wr(2, mk(0, 0, 2, 0, 0, 0, 1, 2));
    restart();
    go(3);
    chk("R10", "word 5 retained", l_o, 65535 - 26);
    wr(0, mk(0, 0, 4, 1, 0, 0, 0, 0));
    restart();
    go(1);
    chk("R9", "full-width mar", mar_o, 16'hFFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule